// File: doc/BRIEF.md
# USB Device Global Interrupt Status Register

This block holds the global interrupt status word of a USB 2.0 high-speed device controller. Single-cycle event pulses from the controller core set sticky status bits: bus reset detected, speed enumeration finished, periodic frame point reached, isochronous OUT packet dropped, and isochronous IN transfer left unfinished. Software clears each of these by writing 1 to its position. Two further bits are read-only summaries. Each is the registered OR of a 16-bit vector of per-endpoint pending flags, one vector for IN endpoints and one for OUT endpoints. These bits drop only when the per-endpoint sources drop.

A small comparator sits beside the register. It decides that an arriving isochronous OUT packet must be dropped when the receive FIFO free space is below that endpoint's maximum packet size. That decision sets the drop bit. A mask register with the same bit layout gates the status word. The interrupt output is the registered OR of the masked status. Software reaches the status word and the mask through a simple synchronous read/write port, and read data is registered.

Top module: `usb_dev_irq_status`

## Requirements
- R1: After synchronous reset, the status word, the mask register, the read data and `irq` are all 0.
- R2: An event pulse on `ev_bus_reset`, `ev_enum_done` or `ev_eopf` sets status bit 12, 13 or 15 respectively, and the bit stays set after the pulse ends.
- R3: A write to address 0 clears each of bits 20, 15, 14, 13 and 12 whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bit 20 is set only when `ev_iso_in_late` and `ev_eopf` are high in the same cycle. `ev_iso_in_late` alone leaves it 0.
- R6: While `sg_dma_mode` is 1, bit 20 is never set, even when both of its events arrive together.
- R7: Bit 19 equals the OR of `out_ep_pend` delayed by one clock. Writing 1 to it has no effect, and it falls one clock after the vector becomes all zeros.
- R8: Bit 18 equals the OR of `in_ep_pend` delayed by one clock, and it ignores writes in the same way as bit 19.
- R9: Bits 17:16 and every other unimplemented position read 0 in both the status word and the mask, whatever is written.
- R10: A cycle with `iso_out_arrive` high and `rx_free_words` strictly less than `iso_out_max_words` sets bit 14. Equal or greater free space does not set it.
- R11: `irq` is 1 exactly one clock after a cycle in which (status AND mask) is nonzero. The mask is written at address 1 and resets to 0.
- R12: Read data is registered. One clock after `reg_addr` is presented, `reg_rdata` shows the status word (address 0), the mask (address 1) or 0 (any other address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (2) | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data (write 1 to clear at address 0) |
| reg_rdata | output | DATA_W (32) | Registered read data |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_enum_done | input | 1 | Speed enumeration finished pulse |
| ev_eopf | input | 1 | Periodic frame point reached pulse |
| ev_iso_in_late | input | 1 | Some isochronous IN endpoint unfinished this microframe |
| sg_dma_mode | input | 1 | Scatter/gather DMA mode active |
| iso_out_arrive | input | 1 | Isochronous OUT packet arriving |
| rx_free_words | input | FIFO_W (12) | Receive FIFO free space |
| iso_out_max_words | input | FIFO_W (12) | Maximum packet size of the arriving endpoint |
| in_ep_pend | input | NUM_EP (16) | Per-IN-endpoint pending flags |
| out_ep_pend | input | NUM_EP (16) | Per-OUT-endpoint pending flags |
| irq | output | 1 | Registered masked interrupt |

## Verification
The bench drives a clear and a set into the same bit in the same cycle. A design that let the clear win would lose the event and read 0. It raises the late-IN event with and without the frame-point event and with scatter/gather mode on. A design that was missing either gate would show bit 20 where it must stay 0. It probes the drop comparator at free space equal to the maximum and one below it, which catches an off-by-one that drops a packet that fits. It writes ones over the summary and reserved bits, so a design that stored those writes would read back a stuck or nonzero value.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
  // Bit positions that software decodes
  localparam int POS_ISO_IN_LATE = 20;
  localparam int POS_OUT_SUM     = 19;
  localparam int POS_IN_SUM      = 18;
  localparam int POS_PER_FRAME   = 15;
  localparam int POS_ISO_DROP    = 14;
  localparam int POS_ENUM        = 13;
  localparam int POS_BUS_RST     = 12;

  // Sticky write-1-clear bits, in the order of the set vector
  localparam int N_W1C = 5;
  localparam int W1C_POS [N_W1C] = '{POS_ISO_IN_LATE, POS_PER_FRAME,
                                     POS_ISO_DROP, POS_ENUM, POS_BUS_RST};

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
endpackage

// File: rtl/irqst_w1c_bit.sv
module irqst_w1c_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // A set in the same cycle as a clear keeps the bit high
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irqst_ep_summary.sv
module irqst_ep_summary #(
  parameter int NUM_EP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] pend_i,
  output logic              any_o
);
  always_ff @(posedge clk) begin
    if (rst) any_o <= 1'b0;
    else     any_o <= |pend_i;
  end
endmodule

// File: rtl/irqst_isodrop.sv
module irqst_isodrop #(
  parameter int FIFO_W = 12
) (
  input  logic              arrive_i,
  input  logic [FIFO_W-1:0] free_i,
  input  logic [FIFO_W-1:0] maxpkt_i,
  output logic              drop_o
);
  // Drop when a full-size packet would not fit
  always_comb drop_o = arrive_i && (free_i < maxpkt_i);
endmodule

// File: rtl/usb_dev_irq_status.sv
module usb_dev_irq_status
  import irqst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int FIFO_W = 12,
  parameter int NUM_EP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_bus_reset,
  input  logic              ev_enum_done,
  input  logic              ev_eopf,
  input  logic              ev_iso_in_late,
  input  logic              sg_dma_mode,
  input  logic              iso_out_arrive,
  input  logic [FIFO_W-1:0] rx_free_words,
  input  logic [FIFO_W-1:0] iso_out_max_words,
  input  logic [NUM_EP-1:0] in_ep_pend,
  input  logic [NUM_EP-1:0] out_ep_pend,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] IMPL_MASK =
      (ONE << POS_ISO_IN_LATE) | (ONE << POS_OUT_SUM) | (ONE << POS_IN_SUM) |
      (ONE << POS_PER_FRAME) | (ONE << POS_ISO_DROP) | (ONE << POS_ENUM) |
      (ONE << POS_BUS_RST);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADDR_MASK);

  logic [DATA_W-1:0] wdata_m;
  logic              wr_status, wr_mask;
  logic              iso_drop;
  logic              out_any, in_any;
  logic [N_W1C-1:0]  w1c_set, w1c_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mask_q;

  always_comb begin
    wdata_m   = reg_wdata & IMPL_MASK;
    wr_status = reg_wr && (reg_addr == A_STATUS);
    wr_mask   = reg_wr && (reg_addr == A_MASK);
  end

  irqst_isodrop #(.FIFO_W(FIFO_W)) u_isodrop (
    .arrive_i (iso_out_arrive),
    .free_i   (rx_free_words),
    .maxpkt_i (iso_out_max_words),
    .drop_o   (iso_drop)
  );

  irqst_ep_summary #(.NUM_EP(NUM_EP)) u_out_sum (
    .clk(clk), .rst(rst), .pend_i(out_ep_pend), .any_o(out_any)
  );
  irqst_ep_summary #(.NUM_EP(NUM_EP)) u_in_sum (
    .clk(clk), .rst(rst), .pend_i(in_ep_pend), .any_o(in_any)
  );

  // Set sources, ordered as W1C_POS
  always_comb begin
    w1c_set[0] = ev_iso_in_late && ev_eopf && !sg_dma_mode;
    w1c_set[1] = ev_eopf;
    w1c_set[2] = iso_drop;
    w1c_set[3] = ev_enum_done;
    w1c_set[4] = ev_bus_reset;
  end

  for (genvar k = 0; k < N_W1C; k++) begin : g_w1c
    irqst_w1c_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (w1c_set[k]),
      .clr_i (wr_status && wdata_m[W1C_POS[k]]),
      .q_o   (w1c_q[k])
    );
  end

  always_comb begin
    status_q = '0;
    for (int k = 0; k < N_W1C; k++) status_q[W1C_POS[k]] = w1c_q[k];
    status_q[POS_OUT_SUM] = out_any;
    status_q[POS_IN_SUM]  = in_any;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_m;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(status_q & mask_q);
      if (reg_addr == A_STATUS)    reg_rdata <= status_q;
      else if (reg_addr == A_MASK) reg_rdata <= mask_q;
      else                         reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/irqst_chk.sv
module irqst_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int NUM_EP = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ev_enum_done,
  input logic              ev_bus_reset,
  input logic              ev_eopf,
  input logic              sg_dma_mode,
  input logic [NUM_EP-1:0] out_ep_pend,
  input logic [NUM_EP-1:0] in_ep_pend,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq
);
  logic clr13;
  always_comb clr13 = reg_wr && (reg_addr == '0) && reg_wdata[13];

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (status_q[13] && !clr13) |=> status_q[13]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    ev_bus_reset |=> status_q[12]);

  p_late_needs_frame_r5: assert property (@(posedge clk) disable iff (rst)
    (!ev_eopf && !status_q[20]) |=> !status_q[20]);

  p_sg_blocks_late_r6: assert property (@(posedge clk) disable iff (rst)
    (sg_dma_mode && !status_q[20]) |=> !status_q[20]);

  p_out_summary_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q[19] == $past(|out_ep_pend)));

  p_in_summary_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q[18] == $past(|in_ep_pend)));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[17:16] == 2'b00) && (mask_q[17:16] == 2'b00));

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status_q & mask_q))));
endmodule

bind usb_dev_irq_status irqst_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_enum_done(ev_enum_done),
  .ev_bus_reset(ev_bus_reset), .ev_eopf(ev_eopf), .sg_dma_mode(sg_dma_mode),
  .out_ep_pend(out_ep_pend), .in_ep_pend(in_ep_pend),
  .status_q(status_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_usb_dev_irq_status.sv
module tb_usb_dev_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_bus_reset = 0, ev_enum_done = 0, ev_eopf = 0, ev_iso_in_late = 0;
  logic        sg_dma_mode = 0, iso_out_arrive = 0;
  logic [11:0] rx_free_words = '0, iso_out_max_words = '0;
  logic [15:0] in_ep_pend = '0, out_ep_pend = '0;
  logic        irq;

  localparam logic [31:0] B20 = 32'h1 << 20, B19 = 32'h1 << 19, B18 = 32'h1 << 18;
  localparam logic [31:0] B15 = 32'h1 << 15, B14 = 32'h1 << 14, B13 = 32'h1 << 13;
  localparam logic [31:0] B12 = 32'h1 << 12;

  usb_dev_irq_status dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  typedef struct { int due; bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops items that are due and compares
  initial forever begin
    @(negedge clk);
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : reg_rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.due = cyc + 1; it.is_irq = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.due = cyc + 1; it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0; reg_addr = 0;
  endtask

  task automatic pulse(input bit br, input bit en, input bit fr, input bit late);
    ev_bus_reset = br; ev_enum_done = en; ev_eopf = fr; ev_iso_in_late = late;
    tick();
    ev_bus_reset = 0; ev_enum_done = 0; ev_eopf = 0; ev_iso_in_late = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    expect_reg(0, 0, "R1 status");
    expect_reg(1, 0, "R1 mask");
    expect_irq(0, "R1 irq");
    // R2 sticky set
    pulse(1, 0, 0, 0);
    expect_reg(0, B12, "R2 bus reset");
    repeat (3) tick();
    expect_reg(0, B12, "R2 hold");
    pulse(0, 1, 0, 0);
    expect_reg(0, B12 | B13, "R2 enum");
    // R3 write 0 no effect, write 1 clears
    wr(0, 32'h0);
    expect_reg(0, B12 | B13, "R3 write0");
    wr(0, B12);
    expect_reg(0, B13, "R3 w1c");
    // R4 set beats clear
    ev_enum_done = 1; wr(0, B13); ev_enum_done = 0;
    expect_reg(0, B13, "R4 set wins");
    wr(0, B13);
    expect_reg(0, 0, "R3 cleared");
    // R5 late IN needs frame point
    pulse(0, 0, 0, 1);
    expect_reg(0, 0, "R5 late alone");
    pulse(0, 0, 1, 1);
    expect_reg(0, B20 | B15, "R5 late+frame");
    wr(0, B20 | B15);
    // R6 scatter/gather suppresses
    sg_dma_mode = 1;
    pulse(0, 0, 1, 1);
    sg_dma_mode = 0;
    expect_reg(0, B15, "R6 sg mode");
    wr(0, B15);
    expect_reg(0, 0, "R3 frame clear");
    // R10 drop compare
    rx_free_words = 12'd100; iso_out_max_words = 12'd100; iso_out_arrive = 1;
    tick(); iso_out_arrive = 0;
    expect_reg(0, 0, "R10 fits");
    rx_free_words = 12'd99; iso_out_arrive = 1;
    tick(); iso_out_arrive = 0;
    expect_reg(0, B14, "R10 drop");
    wr(0, B14);
    // R7 / R8 summaries
    out_ep_pend = 16'h0100; tick();
    expect_reg(0, B19, "R7 out sum");
    wr(0, B19);
    expect_reg(0, B19, "R7 write ignored");
    out_ep_pend = 0; tick();
    expect_reg(0, 0, "R7 fall");
    in_ep_pend = 16'h8000; tick();
    expect_reg(0, B18, "R8 in sum");
    wr(0, B18);
    expect_reg(0, B18, "R8 write ignored");
    in_ep_pend = 0; tick();
    expect_reg(0, 0, "R8 fall");
    // R9 reserved bits, R12 address decode
    wr(0, 32'hFFFF_FFFF);
    expect_reg(0, 0, "R9 status reserved");
    wr(1, 32'hFFFF_FFFF);
    expect_reg(1, 32'h001C_F000, "R9 mask reserved");
    expect_reg(2, 0, "R12 unused addr");
    // R11 masked interrupt
    wr(1, B12);
    expect_irq(0, "R11 empty");
    pulse(0, 1, 0, 0);
    expect_irq(0, "R11 masked off");
    pulse(1, 0, 0, 0);
    expect_irq(1, "R11 asserted");
    wr(0, B12);
    expect_irq(0, "R11 deasserted");
    wr(1, B19);
    out_ep_pend = 16'h0001; tick();
    expect_irq(1, "R11 summary");
    expect_reg(1, B19, "R12 mask read");
    out_ep_pend = 0;
    repeat (4) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule